// File: doc/BRIEF.md
# Page Write Staging and Commit Engine

This block collects the data bytes of one write transfer in a page-sized staging buffer and, once the transfer is closed, hands the whole page to the memory array in one write. A transfer opens with a start strobe that carries a byte address. The upper address bits pick the page and stay fixed for the rest of the transfer. The low bits give the first offset, and each accepted byte moves the offset on by one. Offsets wrap inside the page, so a transfer longer than the page overwrites bytes it staged earlier.

When the end strobe arrives and at least one byte is staged, the engine raises a one-cycle write on a wide port. The port carries the page number, every lane's data and a byte-enable mask of the offsets that were written. The engine then stays busy for a programmable number of cycles that models the array's write time. While busy it refuses new transfers and ignores every other strobe. An abort strobe, which upstream logic raises when a protection check or a protocol error rejects the transfer, drops the staged bytes without writing anything.

Top module: `page_stage_commit`

## Requirements
- R1: After reset, busy_o, mem_we_o and every bit of mem_be_o are 0.
- R2: An accepted start_i latches start_addr_i. mem_page_o shows start_addr_i[ADDR_W-1:OFF_W]. The first byte goes to offset start_addr_i[OFF_W-1:0], and each following byte goes to the next offset. Lane k of the page is mem_wdata_o[k*DATA_W +: DATA_W], and its enable is mem_be_o[k].
- R3: After offset 2**OFF_W-1 the next byte goes to offset 0 of the same page. A later byte at an offset replaces the earlier one.
- R4: mem_we_o stays 0 while a transfer is collecting bytes.
- R5: If end_i is sampled during a transfer with at least one byte staged, mem_we_o is 1 for exactly the following cycle. In that cycle the port shows the staged page data.
- R6: In the commit cycle, mem_be_o has a 1 only at offsets that received a byte in this transfer.
- R7: busy_o rises in the commit cycle and stays high for exactly WRITE_CYCLES cycles. It falls in the cycle the engine is idle again, and mem_be_o is then all zero.
- R8: While busy_o is 1, start_i, byte_valid_i, end_i and abort_i have no effect: the commit's page, enables and duration are unchanged, and no transfer is open afterwards. A start_i is accepted in the first cycle in which busy_o is 0.
- R9: end_i with no byte staged produces no write and leaves busy_o at 0.
- R10: abort_i during a transfer discards the staged bytes and closes the transfer with no write. A later end_i then does nothing.
- R11: byte_valid_i and end_i outside a transfer are ignored.
- R12: In the same cycle, abort_i takes priority over start_i, end_i and byte_valid_i. start_i during a transfer restarts it and discards the staged bytes. end_i drops a byte_valid_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open a transfer |
| start_addr_i | input | ADDR_W | Starting byte address for start_i |
| byte_valid_i | input | 1 | Data byte present |
| byte_data_i | input | DATA_W | Data byte |
| end_i | input | 1 | Close the transfer and commit |
| abort_i | input | 1 | Drop the transfer without committing |
| busy_o | output | 1 | Commit in progress |
| mem_we_o | output | 1 | One-cycle page write to the array |
| mem_page_o | output | ADDR_W-OFF_W | Page number for the write |
| mem_be_o | output | 2**OFF_W | Per-offset write enables |
| mem_wdata_o | output | DATA_W*2**OFF_W | All lanes of page data |

## Verification
The bench sweeps every starting offset against transfer lengths from one byte to beyond a full page, and predicts the enables and lane contents with modular arithmetic. A design that let the offset carry into the page number, or that kept the first copy of a wrapped byte, would show the wrong page or lane data. Directed sequences then target the strobe corners: end with nothing staged, abort followed by end, a restart part way through a transfer, end together with a byte, and every kind of strobe during the busy window. A design that committed an empty page, let a strobe leak through while busy, or miscounted the write time would show a write pulse, stale enables or a busy window of the wrong length.

// File: rtl/page_stage_pkg.sv
package page_stage_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_FILL = 2'd1,
      PS_HOLD = 2'd2
   } ps_state_e;

   function automatic int ps_cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ps_offset_track.sv
module ps_offset_track #(
   parameter int ADDR_W = 11,
   parameter int OFF_W  = 4,
   localparam int PAGE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [OFF_W-1:0]  off_o
);

   if (OFF_W < 1 || ADDR_W <= OFF_W) begin : g_bad_geom
      $error("ps_offset_track: need 1 <= OFF_W < ADDR_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
         off_o  <= '0;
      end else if (load_i) begin
         page_o <= addr_i[ADDR_W-1:OFF_W];
         off_o  <= addr_i[OFF_W-1:0];
      end else if (step_i) begin
         off_o  <= off_o + 1'b1;
      end
   end

   // only a load may move the page select; stepping wraps the offset
   assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(page_o));

endmodule

// File: rtl/ps_lane_buffer.sv
module ps_lane_buffer #(
   parameter int DATA_W = 8,
   parameter int OFF_W  = 4,
   localparam int LANES = 1 << OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    wr_i,
   input  logic [OFF_W-1:0]        wr_off_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   output logic [LANES*DATA_W-1:0] data_o,
   output logic [LANES-1:0]        mask_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("ps_lane_buffer: DATA_W must be positive");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = wr_i && (wr_off_i == OFF_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[g*DATA_W +: DATA_W] <= '0;
         end else if (hit) begin
            data_o[g*DATA_W +: DATA_W] <= wr_data_i;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_o[g] <= 1'b0;
         end else if (clr_i) begin
            mask_o[g] <= 1'b0;
         end else if (hit) begin
            mask_o[g] <= 1'b1;
         end
      end

      // an enable only appears at an offset that took a byte
      assert_mask_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mask_o[g]) |-> $past(wr_i) && ($past(wr_off_i) == OFF_W'(g)));
   end

   // the control never clears and stores in the same cycle
   assert_clr_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i && wr_i));

endmodule

// File: rtl/ps_write_timer.sv
module ps_write_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic busy_o,
   output logic last_o
);

   import page_stage_pkg::*;

   localparam int CW = ps_cnt_width(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("ps_write_timer: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_o <= 1'b0;
         else        busy_o <= fire_i;
      end
      assign last_o = busy_o;
   end else begin : g_count
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
         end else if (fire_i) begin
            busy_o <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
         end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end

      assign last_o = busy_o && (cnt_q == '0);

      assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
         busy_o |-> (cnt_q <= CW'(CYCLES - 1)));
   end

   // a new commit is only launched from an idle timer
   assert_fire_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> !busy_o);

endmodule

// File: rtl/page_stage_commit.sv
module page_stage_commit #(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 8,
   parameter int OFF_W        = 4,
   parameter int WRITE_CYCLES = 1000,
   localparam int LANES  = 1 << OFF_W,
   localparam int PAGE_W = ADDR_W - OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [ADDR_W-1:0]       start_addr_i,
   input  logic                    byte_valid_i,
   input  logic [DATA_W-1:0]       byte_data_i,
   input  logic                    end_i,
   input  logic                    abort_i,
   output logic                    busy_o,
   output logic                    mem_we_o,
   output logic [PAGE_W-1:0]       mem_page_o,
   output logic [LANES-1:0]        mem_be_o,
   output logic [LANES*DATA_W-1:0] mem_wdata_o
);

   import page_stage_pkg::*;

   if (WRITE_CYCLES < 1 || OFF_W < 1 || ADDR_W <= OFF_W) begin : g_bad_params
      $error("page_stage_commit: illegal parameter set");
   end

   ps_state_e        state_q;
   logic [OFF_W-1:0] off;
   logic             fill, do_abort, do_start, do_end, do_commit, do_byte;
   logic             buf_clr, timer_last;

   assign fill      = (state_q == PS_FILL);
   assign do_abort  = fill && abort_i;
   assign do_start  = start_i && (state_q != PS_HOLD) && !do_abort;
   assign do_end    = fill && !abort_i && !start_i && end_i;
   assign do_commit = do_end && (|mem_be_o);
   assign do_byte   = fill && !abort_i && !start_i && !end_i && byte_valid_i;
   assign buf_clr   = do_abort || do_start || (state_q == PS_HOLD && timer_last);

   ps_offset_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_offset (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (do_start),
      .addr_i (start_addr_i),
      .step_i (do_byte),
      .page_o (mem_page_o),
      .off_o  (off)
   );

   ps_lane_buffer #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (buf_clr),
      .wr_i      (do_byte),
      .wr_off_i  (off),
      .wr_data_i (byte_data_i),
      .data_o    (mem_wdata_o),
      .mask_o    (mem_be_o)
   );

   ps_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (do_commit),
      .busy_o (busy_o),
      .last_o (timer_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PS_IDLE;
         mem_we_o <= 1'b0;
      end else begin
         mem_we_o <= do_commit;
         unique case (state_q)
            PS_IDLE: if (do_start) state_q <= PS_FILL;
            PS_FILL: begin
               if (do_abort)       state_q <= PS_IDLE;
               else if (do_commit) state_q <= PS_HOLD;
               else if (do_end)    state_q <= PS_IDLE;
            end
            PS_HOLD: if (timer_last) state_q <= PS_IDLE;
            default: state_q <= PS_IDLE;
         endcase
      end
   end

   assert_no_write_filling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> !mem_we_o);

   assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);

   assert_we_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_be_o != '0));

   assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mem_we_o);

   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mem_we_o) |-> ($stable(mem_page_o) && $stable(mem_be_o)
                                 && $stable(mem_wdata_o)));

endmodule

// File: tb/page_stage_commit_test.sv
`timescale 1ns/1ps
module page_stage_commit_test;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int OW = 4;
   localparam int WC = 6;
   localparam int NL = 1 << OW;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [AW-1:0]      start_addr_i = '0;
   logic               byte_valid_i = 1'b0;
   logic [DW-1:0]      byte_data_i = '0;
   logic               end_i = 1'b0;
   logic               abort_i = 1'b0;
   logic               busy_o, mem_we_o;
   logic [AW-OW-1:0]   mem_page_o;
   logic [NL-1:0]      mem_be_o;
   logic [NL*DW-1:0]   mem_wdata_o;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   page_stage_commit #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .WRITE_CYCLES(WC)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .end_i(end_i),
      .abort_i(abort_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
      .mem_page_o(mem_page_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         vectors++;
         fails++;
         $display("FAIL R7 watchdog expired act=%0d exp=<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [NL*DW-1:0] act, input logic [NL*DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      start_i = 0; byte_valid_i = 0; end_i = 0; abort_i = 0;
   endtask

   // after the end edge: check the pulse and a busy window of WC cycles
   task automatic check_commit(input logic [AW-OW-1:0] pg, input logic [NL-1:0] be,
                               input logic [NL*DW-1:0] dat);
      logic [NL*DW-1:0] act_m;
      act_m = '0;
      for (int k = 0; k < NL; k++)
         if (be[k]) act_m[k*DW +: DW] = mem_wdata_o[k*DW +: DW];
      chk("R5 write pulse", mem_we_o, 1);
      chk("R2 page", mem_page_o, pg);
      chk("R6 enables", mem_be_o, be);
      chk("R3 lane data", act_m, dat);
      chk("R7 busy rises", busy_o, 1);
      for (int k = 2; k <= WC; k++) begin
         @(negedge clk);
         chk("R7 busy held", busy_o, 1);
         chk("R5 single pulse", mem_we_o, 0);
      end
      @(negedge clk);
      chk("R7 busy falls", busy_o, 0);
      chk("R7 enables cleared", mem_be_o, 0);
   endtask

   task automatic no_commit(input string tag);
      chk({tag, " no write"}, mem_we_o, 0);
      chk({tag, " not busy"}, busy_o, 0);
   endtask

   initial begin
      logic [NL-1:0]    ebe;
      logic [NL*DW-1:0] edat;
      logic [DW-1:0]    d;
      int               o;

      repeat (3) @(negedge clk);
      chk("R1 busy", busy_o, 0);
      chk("R1 write", mem_we_o, 0);
      chk("R1 enables", mem_be_o, 0);
      rst_n = 1'b1;

      // sweep of start offset and length, including wrap past the page end
      for (int sa = 0; sa < NL; sa++) begin
         for (int len = 1; len <= NL + 4; len++) begin
            ebe = '0; edat = '0;
            @(negedge clk);
            start_i = 1; start_addr_i = AW'(((sa + len) % 16) * NL + sa);
            for (int i = 0; i < len; i++) begin
               @(negedge clk);
               if (i > 0) chk("R4 no early write", mem_we_o, 0);
               idle_inputs();
               d = DW'(sa * 7 + len * 13 + i * 29 + 1);
               o = (sa + i) % NL;
               byte_valid_i = 1; byte_data_i = d;
               ebe[o] = 1'b1;
               edat[o*DW +: DW] = d;
            end
            @(negedge clk);
            chk("R4 no early write", mem_we_o, 0);
            idle_inputs(); end_i = 1;
            @(negedge clk);
            idle_inputs();
            check_commit(AW'((sa + len) % 16), ebe, edat);
         end
      end

      // R9: end with nothing staged
      start_i = 1; start_addr_i = 8'h35;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      no_commit("R9");
      @(negedge clk); no_commit("R9");

      // R10: abort discards, later end ignored, next transfer starts clean
      start_i = 1; start_addr_i = 8'h40;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = DW'(8'hA0 + i);
      end
      @(negedge clk); idle_inputs(); abort_i = 1;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      no_commit("R10");
      start_i = 1; start_addr_i = 8'h47;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h5C;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'h4, 16'h0080, 128'h5C << (7 * DW));

      // R11: bytes and end outside a transfer ignored
      byte_valid_i = 1; byte_data_i = 8'hEE;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      no_commit("R11");
      start_i = 1; start_addr_i = 8'h92;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h11;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'h9, 16'h0004, 128'h11 << (2 * DW));

      // R12: end drops a byte in the same cycle
      start_i = 1; start_addr_i = 8'h1E;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h77;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h88; end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'h1, 16'h4000, 128'h77 << (14 * DW));

      // R12: abort wins over end
      start_i = 1; start_addr_i = 8'h23;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h66;
      @(negedge clk); idle_inputs(); abort_i = 1; end_i = 1; start_i = 1; start_addr_i = 8'h24;
      @(negedge clk); idle_inputs();
      no_commit("R12 abort priority");
      end_i = 1;
      @(negedge clk); idle_inputs();
      no_commit("R12 abort closes");

      // R12: restart inside a transfer discards earlier bytes
      start_i = 1; start_addr_i = 8'h50;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h01;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h02;
      @(negedge clk); idle_inputs(); start_i = 1; start_addr_i = 8'hC9;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h3D;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'hC, 16'h0200, 128'h3D << (9 * DW));

      // R8: strobes during busy have no effect
      start_i = 1; start_addr_i = 8'h6B;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'hB4;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      chk("R8 commit pulse", mem_we_o, 1);
      start_i = 1; start_addr_i = 8'hF0;
      for (int k = 2; k <= WC; k++) begin
         @(negedge clk);
         chk("R8 busy held", busy_o, 1);
         chk("R8 page kept", mem_page_o, 4'h6);
         chk("R8 enables kept", mem_be_o, 16'h0800);
         idle_inputs();
         if (k == 2) begin byte_valid_i = 1; byte_data_i = 8'h99; end
         if (k == 3) abort_i = 1;
         if (k == 4) end_i = 1;
         if (k == 5) begin start_i = 1; start_addr_i = 8'hF3; byte_valid_i = 1; end
      end
      @(negedge clk); idle_inputs();
      chk("R8 busy length", busy_o, 0);
      end_i = 1;
      @(negedge clk); idle_inputs();
      no_commit("R8 start refused");

      // R8: start accepted in the first idle cycle after a commit
      start_i = 1; start_addr_i = 8'h0F;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h21;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'h0, 16'h8000, 128'h21 << (15 * DW));
      start_i = 1; start_addr_i = 8'hA0;
      @(negedge clk); idle_inputs(); byte_valid_i = 1; byte_data_i = 8'h42;
      @(negedge clk); idle_inputs(); end_i = 1;
      @(negedge clk); idle_inputs();
      check_commit(4'hA, 16'h0001, 128'h42);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule